// File: doc/BRIEF.md
# Oversampling Serial Receiver with Four-Byte Queue

This block is the receive half of a fixed-format asynchronous serial port. A programmable divisor produces a sample tick four times per bit period. The incoming line is synchronised, and a start bit is validated. The eight data bits are captured least significant first, and the stop bit is checked. Each finished byte goes into a small queue that software or a bus adapter drains with a pop strobe.

The queue holds four bytes. It reports empty, full and "exactly one free slot" as separate outputs. Two sticky error flags record a bad stop bit and a byte that arrived while the queue was full. Each flag is cleared by its own strobe. The bus interface, the transmitter and interrupt generation are not part of this block.

Top module: `serial_rx_core`

## Requirements
- R1: A sample tick occurs once every `divisor_i + 1` clock cycles, so one bit period lasts `4 * (divisor_i + 1)` clocks. Bytes sent at that bit period are received correctly for any divisor.
- R2: After reset, the queue is empty (`empty_o`=1, `full_o`=0, `one_left_o`=0) and both error flags are 0. The line passes through two synchronising flops before it is sampled.
- R3: The frame is one low start bit, then eight data bits least significant bit first, then one high stop bit, with no parity. The received byte appears on `head_o` with its bit 0 taken from the first data bit.
- R4: A start is accepted only if the line is still low on the second tick after the low level was first seen. A low pulse shorter than one tick produces no byte.
- R5: The queue stores up to four bytes and returns them in arrival order. `head_o` always shows the oldest stored byte.
- R6: `full_o` is 1 when four bytes are stored. `one_left_o` is 1 only when exactly three bytes are stored. `empty_o` is 1 only when none are stored.
- R7: When the stop-bit sample is low, `frame_err_o` is set. The byte is still stored if there is room.
- R8: When a byte completes while the queue is full, `ovr_err_o` is set. The new byte is dropped and the four stored bytes stay unchanged.
- R9: Each error flag stays at 1 until its own clear strobe (`clr_frame_i` or `clr_ovr_i`) is pulsed. A clear strobe affects only its own flag.
- R10: A pop while the queue is empty has no effect. A pop and a push in the same cycle leave the stored count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial line, idle high |
| divisor_i | input | 16 | Tick divisor; tick period is divisor + 1 clocks |
| pop_i | input | 1 | Removes the head byte from the queue |
| clr_frame_i | input | 1 | Clears the frame-error flag |
| clr_ovr_i | input | 1 | Clears the overrun flag |
| head_o | output | 8 | Oldest byte in the queue |
| empty_o | output | 1 | Queue holds no byte |
| full_o | output | 1 | Queue holds four bytes |
| one_left_o | output | 1 | Queue has exactly one free slot |
| frame_err_o | output | 1 | Sticky flag: stop bit sampled low |
| ovr_err_o | output | 1 | Sticky flag: byte arrived while full |

## Verification
The assertions check the following on every cycle:
- the tick spacing;
- that the receive state changes only on ticks;
- the queue-count bounds;
- the overrun flag and the count being held when a byte arrives while the queue is full;
- that the error flags stay set;
- the count being held on a simultaneous push and pop.

Only the bench scenarios can show the parts that depend on whole frames:
- correct bit order at two different divisors;
- rejection of a short start glitch;
- arrival order through a full queue;
- a byte being kept alongside a frame error.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } rx_state_e;

  localparam int unsigned TICKS_PER_BIT = 4;
  localparam int unsigned START_CONFIRM = 2;
endpackage

// File: rtl/srx_tick.sv
module srx_tick #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] divisor_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = (cnt_q >= divisor_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // R1: with a nonzero, steady divisor two ticks are never adjacent
  p_tick_gap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && divisor_i != '0) ##1 $stable(divisor_i) |-> !tick_o);
endmodule

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '1;
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/srx_fsm.sv
module srx_fsm
  import srx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rx_i,
  output logic              push_o,
  output logic [DATA_W-1:0] byte_o,
  output logic              ferr_o
);
  localparam int unsigned BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int unsigned TW = $clog2(TICKS_PER_BIT);
  localparam logic [TW-1:0] T_LAST = TW'(TICKS_PER_BIT - 1);
  localparam logic [TW-1:0] T_CONF = TW'(START_CONFIRM - 1);
  localparam logic [BW-1:0] B_LAST = BW'(DATA_W - 1);

  rx_state_e         state_q;
  logic [TW-1:0]     tcnt_q;
  logic [BW-1:0]     bcnt_q;
  logic [DATA_W-1:0] shreg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tcnt_q  <= '0;
      bcnt_q  <= '0;
      shreg_q <= '0;
      push_o  <= 1'b0;
      byte_o  <= '0;
      ferr_o  <= 1'b0;
    end else begin
      push_o <= 1'b0;
      if (tick_i) begin
        unique case (state_q)
          ST_IDLE: begin
            if (!rx_i) begin
              state_q <= ST_START;
              tcnt_q  <= '0;
            end
          end
          ST_START: begin
            if (tcnt_q == T_CONF) begin
              tcnt_q <= '0;
              bcnt_q <= '0;
              state_q <= rx_i ? ST_IDLE : ST_DATA;
            end else begin
              tcnt_q <= tcnt_q + 1'b1;
            end
          end
          ST_DATA: begin
            if (tcnt_q == T_LAST) begin
              tcnt_q  <= '0;
              shreg_q <= {rx_i, shreg_q[DATA_W-1:1]};
              if (bcnt_q == B_LAST) state_q <= ST_STOP;
              else                  bcnt_q  <= bcnt_q + 1'b1;
            end else begin
              tcnt_q <= tcnt_q + 1'b1;
            end
          end
          ST_STOP: begin
            if (tcnt_q == T_LAST) begin
              tcnt_q  <= '0;
              push_o  <= 1'b1;
              byte_o  <= shreg_q;
              ferr_o  <= !rx_i;
              state_q <= ST_IDLE;
            end else begin
              tcnt_q <= tcnt_q + 1'b1;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  // R1: the receiver advances only on sample ticks
  p_state_on_tick_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(state_q));
  // R3: one push per frame, never back to back
  p_push_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |=> !push_o);
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              ferr_i,
  input  logic              pop_i,
  input  logic              clr_frame_i,
  input  logic              clr_ovr_i,
  output logic [DATA_W-1:0] head_o,
  output logic              empty_o,
  output logic              full_o,
  output logic              one_left_o,
  output logic              frame_err_o,
  output logic              ovr_err_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] P_LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] C_FULL = CW'(DEPTH);
  localparam logic [CW-1:0] C_ONE  = CW'(DEPTH - 1);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PW-1:0]     wr_q, rd_q;
  logic [CW-1:0]     cnt_q;
  logic              do_push, do_pop;

  assign full_o     = (cnt_q == C_FULL);
  assign empty_o    = (cnt_q == '0);
  assign one_left_o = (cnt_q == C_ONE);
  assign do_push    = push_i && !full_o;
  assign do_pop     = pop_i && !empty_o;
  assign head_o     = mem_q[rd_q];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          mem_q[g] <= '0;
      else if (do_push && wr_q == PW'(g))   mem_q[g] <= byte_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == P_LAST) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == P_LAST) ? '0 : rd_q + 1'b1;
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_err_o <= 1'b0;
      ovr_err_o   <= 1'b0;
    end else begin
      if (push_i && ferr_i)  frame_err_o <= 1'b1;
      else if (clr_frame_i)  frame_err_o <= 1'b0;
      if (push_i && full_o)  ovr_err_o   <= 1'b1;
      else if (clr_ovr_i)    ovr_err_o   <= 1'b0;
    end
  end

  p_count_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= C_FULL);
  p_flags_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(empty_o && full_o));
  p_frame_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && ferr_i |=> frame_err_o);
  p_ovr_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && full_o |=> ovr_err_o);
  p_ovr_keep_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && full_o && !pop_i |=> full_o && $stable(rd_q));
  p_frame_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o && !clr_frame_i |=> frame_err_o);
  p_ovr_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_err_o && !clr_ovr_i |=> ovr_err_o);
  p_push_pop_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && pop_i && !empty_o && !full_o |=> $stable(cnt_q));
  p_empty_pop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && empty_o && !push_i |=> empty_o);
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core #(
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_i,
  input  logic [DIV_W-1:0]  divisor_i,
  input  logic              pop_i,
  input  logic              clr_frame_i,
  input  logic              clr_ovr_i,
  output logic [DATA_W-1:0] head_o,
  output logic              empty_o,
  output logic              full_o,
  output logic              one_left_o,
  output logic              frame_err_o,
  output logic              ovr_err_o
);
  logic              tick, rx_s, push, ferr;
  logic [DATA_W-1:0] rx_byte;

  srx_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i, .rst_ni, .divisor_i, .tick_o(tick)
  );

  srx_sync #(.STAGES(2)) u_sync (
    .clk_i, .rst_ni, .d_i(rx_i), .q_o(rx_s)
  );

  srx_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk_i, .rst_ni, .tick_i(tick), .rx_i(rx_s),
    .push_o(push), .byte_o(rx_byte), .ferr_o(ferr)
  );

  srx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni, .push_i(push), .byte_i(rx_byte), .ferr_i(ferr),
    .pop_i, .clr_frame_i, .clr_ovr_i, .head_o, .empty_o, .full_o,
    .one_left_o, .frame_err_o, .ovr_err_o
  );
endmodule

// File: tb/sim_serial_rx_core.sv
`timescale 1ns/1ps
module sim_serial_rx_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx = 1'b1;
  logic [15:0] div = 16'd3;
  logic        pop = 1'b0, clr_f = 1'b0, clr_o = 1'b0;
  logic [7:0]  head;
  logic        empty, full, one_left, ferr, ovr;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  serial_rx_core u0 (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .divisor_i(div), .pop_i(pop),
    .clr_frame_i(clr_f), .clr_ovr_i(clr_o), .head_o(head), .empty_o(empty),
    .full_o(full), .one_left_o(one_left), .frame_err_o(ferr), .ovr_err_o(ovr)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_bits(input int n);
    repeat (n * 4 * (int'(div) + 1)) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, input logic stop);
    rx = 1'b0; wait_bits(1);
    for (int i = 0; i < 8; i++) begin rx = b[i]; wait_bits(1); end
    rx = stop; wait_bits(1);
    rx = 1'b1; wait_bits(2);
  endtask

  task automatic do_pop();
    @(negedge clk); pop = 1'b1;
    @(negedge clk); pop = 1'b0;
  endtask

  task automatic t_reset();
    chk("R2 empty", empty, 1);
    chk("R2 full", full, 0);
    chk("R2 one_left", one_left, 0);
    chk("R2 frame_err", ferr, 0);
    chk("R2 ovr_err", ovr, 0);
  endtask

  task automatic t_basic();
    div = 16'd3;
    send(8'hA5, 1'b1);
    chk("R3 not empty", empty, 0);
    chk("R3 byte lsb first", head, 8'hA5);
    do_pop();
    chk("R3 empty after pop", empty, 1);
    div = 16'd7;
    @(negedge clk);
    send(8'h3C, 1'b1);
    chk("R1 byte at div 7", head, 8'h3C);
    do_pop();
    div = 16'd3;
    @(negedge clk);
  endtask

  task automatic t_glitch();
    rx = 1'b0; repeat (2) @(negedge clk); rx = 1'b1;
    wait_bits(12);
    chk("R4 glitch ignored", empty, 1);
  endtask

  task automatic t_fill();
    send(8'h11, 1'b1); send(8'h22, 1'b1); send(8'h33, 1'b1);
    chk("R6 one_left at 3", one_left, 1);
    chk("R6 not full at 3", full, 0);
    send(8'h44, 1'b1);
    chk("R6 full at 4", full, 1);
    chk("R6 one_left at 4", one_left, 0);
    chk("R8 no overrun yet", ovr, 0);
    send(8'h55, 1'b1);
    chk("R8 overrun flag", ovr, 1);
    chk("R5 head oldest", head, 8'h11);
    do_pop(); chk("R5 order 2", head, 8'h22);
    do_pop(); chk("R5 order 3", head, 8'h33);
    do_pop(); chk("R8 last kept", head, 8'h44);
    do_pop(); chk("R8 overrun byte dropped", empty, 1);
  endtask

  task automatic t_pop_empty();
    do_pop();
    chk("R10 pop on empty", empty, 1);
    send(8'h5A, 1'b1);
    chk("R10 head after empty pop", head, 8'h5A);
    chk("R10 count one", one_left | full, 0);
    do_pop();
    chk("R10 empty again", empty, 1);
  endtask

  task automatic t_frame();
    send(8'h81, 1'b0);
    chk("R7 frame flag", ferr, 1);
    chk("R7 byte kept", head, 8'h81);
    send(8'h7E, 1'b1);
    chk("R9 frame sticky", ferr, 1);
    chk("R9 ovr sticky", ovr, 1);
    @(negedge clk); clr_f = 1'b1; @(negedge clk); clr_f = 1'b0;
    chk("R9 frame cleared", ferr, 0);
    chk("R9 ovr untouched", ovr, 1);
    @(negedge clk); clr_o = 1'b1; @(negedge clk); clr_o = 1'b0;
    chk("R9 ovr cleared", ovr, 0);
    do_pop();
    chk("R5 second after frame", head, 8'h7E);
    do_pop();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_basic();
    t_glitch();
    t_fill();
    t_pop_empty();
    t_frame();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule